// File: doc/BRIEF.md
# Indirect Local Memory Access Window

This block gives a host a register-mapped path into two local word memories: one holds instructions and one holds data. The host never addresses the memories directly. Each memory has a control register that holds a byte address, and a data register that works as a streaming window onto the word at that address. With the matching increment enable set, every data register access moves the address on by one word. A loader can therefore fill or dump a whole memory region with back-to-back accesses to a single register.

Next to the two windows are a few more registers:
- a CPU control register with start and halt-interrupt bits;
- a mailbox register that is cleared when the CPU is started;
- two read-only configuration words that report memory size and port count.

The host side is a plain 32-bit register bus. A write takes effect on the next clock edge. Read data is returned in the same cycle as the read strobe.

Top module: `lmem_access_port`

## Requirements
- R1: After an active-low reset, the following all read zero:
  - both control registers,
  - the CPU control register,
  - the mailbox,
  - every memory word.
- R2: The memory word index is control-register bits [IDX_W+1:2], where IDX_W = log2(MEM_BYTES/4). Bits [1:0] are ignored for addressing. Bits above the index field do not affect which word is selected, so the address wraps modulo MEM_BYTES (default 1024).
- R3: A write to a data register stores the word at the addressed location. If that memory's write-increment bit (bit 24 of its control register) is set, the index then advances by one word.
- R4: A read of a data register returns the addressed word. If that memory's read-increment bit (bit 25) is set, the index then advances by one word.
- R5: When the increment bit for the access direction is clear, the data access still happens and the control register is left unchanged.
- R6: An advance rewrites only bits [15:2] of the control register. Bits [31:16] and [1:0] keep their values.
- R7: A read of the data-memory control register returns only bits [15:2], with all other bits reading zero. A read of the instruction-memory control register returns the full stored value.
- R8: The two memories are independent: an access through one window never changes the contents of the other memory.
- R9: Writing exactly 0x2 to the CPU control register ORs bit 1 (start) into its current value and clears the mailbox to zero.
- R10: Writing exactly 0x10 to the CPU control register ORs bit 4 (halt interrupt) into its current value.
- R11: Any other write to the CPU control register stores the written value. The mailbox is a plain read/write register.
- R12: The configuration words are read-only; writes to them are ignored.
  - Config word 0 reads (B<<9)|B, where B = MEM_BYTES/256. This is 0x804 by default.
  - Config word 1 reads 0x1100.
- R13: The register byte offsets are:

  | Offset | Register |
  |--------|----------|
  | 0x00 | instruction control |
  | 0x04 | instruction data |
  | 0x08 | data control |
  | 0x0C | data data |
  | 0x10 | CPU control |
  | 0x14 | mailbox |
  | 0x18 | config 0 |
  | 0x1C | config 1 |

  Any other address, including a misaligned one, reads zero and ignores writes. Read data is valid in the same cycle as the read strobe.
- R14: An advance from the last word of a memory wraps the index to word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, same cycle as bus_rd |

## Verification
The assertions watch several properties on every cycle:
- the one-word advance after an incrementing write;
- the control register holding still when the increment bit is clear;
- the preservation of the non-address bits across any data access;
- the masked view of the data control register;
- the mailbox clear on a start command;
- the constant configuration word and the zero read-back of unmapped addresses.

Memory contents can only be shown by the bench's directed scenarios. These cover:
- streamed fills read back in order;
- isolation between the two memories;
- address aliasing through bits [1:0] and through high bits;
- wrap from the last word;
- the OR-in behaviour of the CPU command patterns.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

    localparam int BUS_W      = 32;
    localparam int NBANK      = 2;
    localparam int BLK_BYTES  = 256;

    // register selector, taken from byte address bits [4:2]
    // control of bank b sits at 2*b, its data window at 2*b+1
    typedef enum logic [2:0] {
        SEL_ICTL = 3'd0,
        SEL_IDAT = 3'd1,
        SEL_DCTL = 3'd2,
        SEL_DDAT = 3'd3,
        SEL_CPU  = 3'd4,
        SEL_MBOX = 3'd5,
        SEL_CFG0 = 3'd6,
        SEL_CFG1 = 3'd7
    } reg_sel_e;

    localparam int WINC_BIT   = 24;
    localparam int RINC_BIT   = 25;
    localparam int START_BIT  = 1;
    localparam int HALT_BIT   = 4;

    localparam logic [BUS_W-1:0] START_PAT  = 32'h0000_0002;
    localparam logic [BUS_W-1:0] HALT_PAT   = 32'h0000_0010;
    localparam logic [BUS_W-1:0] FIELD_MASK = 32'h0000_FFFC;
    localparam logic [BUS_W-1:0] CFG1_VAL   = 32'h0000_1100;

    typedef struct packed {
        logic [NBANK-1:0][BUS_W-1:0] ctl;
        logic [BUS_W-1:0]            cpu;
        logic [BUS_W-1:0]            mbox;
    } regs_t;

endpackage

// File: rtl/lmem_bank.sv
module lmem_bank #(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = mem_q[idx];

endmodule

// File: rtl/lmem_ctl_step.sv
module lmem_ctl_step #(
    parameter int IDX_W = 8,
    parameter int DW    = 32
) (
    input  logic [DW-1:0]    ctl_in,
    output logic [IDX_W-1:0] idx,
    output logic [DW-1:0]    ctl_adv
);

    // word index lives above the two ignored byte bits
    assign idx = ctl_in[IDX_W+1:2];

    always_comb begin
        ctl_adv              = ctl_in;
        ctl_adv[15:2]        = '0;
        ctl_adv[IDX_W+1:2]   = idx + 1'b1;
    end

endmodule

// File: rtl/lmem_access_port.sv
module lmem_access_port
    import lmem_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [BUS_W-1:0]  bus_rdata
);

    localparam int DEPTH  = MEM_BYTES / 4;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int BLOCKS = MEM_BYTES / BLK_BYTES;
    localparam logic [BUS_W-1:0] CFG0_VAL = BUS_W'((BLOCKS << 9) | BLOCKS);

    regs_t r_q, r_d;

    logic                  hit;
    reg_sel_e              sel;
    logic [NBANK-1:0]      ctl_hit, dat_hit, mem_we;
    logic [IDX_W-1:0]      idx     [NBANK];
    logic [BUS_W-1:0]      adv     [NBANK];
    logic [BUS_W-1:0]      mem_rd  [NBANK];

    // decode: upper bits and bits [1:0] must be zero
    assign hit = (bus_addr[ADDR_W-1:5] == '0) && (bus_addr[1:0] == 2'b00);
    assign sel = reg_sel_e'(bus_addr[4:2]);

    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            ctl_hit[b] = hit && (sel == reg_sel_e'(3'(2 * b)));
            dat_hit[b] = hit && (sel == reg_sel_e'(3'(2 * b + 1)));
        end
    end

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            lmem_ctl_step #(.IDX_W(IDX_W), .DW(BUS_W)) u_step (
                .ctl_in  (r_q.ctl[b]),
                .idx     (idx[b]),
                .ctl_adv (adv[b])
            );
            lmem_bank #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DW(BUS_W)) u_mem (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (mem_we[b]),
                .idx   (idx[b]),
                .wdata (bus_wdata),
                .rdata (mem_rd[b])
            );
        end
    endgenerate

    // next-state computation
    always_comb begin
        r_d = r_q;
        for (int b = 0; b < NBANK; b++) begin
            mem_we[b] = bus_wr && dat_hit[b];
            if (bus_wr && ctl_hit[b]) begin
                r_d.ctl[b] = bus_wdata;
            end else if (bus_wr && dat_hit[b]) begin
                if (r_q.ctl[b][WINC_BIT]) r_d.ctl[b] = adv[b];
            end else if (!bus_wr && bus_rd && dat_hit[b]) begin
                if (r_q.ctl[b][RINC_BIT]) r_d.ctl[b] = adv[b];
            end
        end
        if (bus_wr && hit && sel == SEL_CPU) begin
            if (bus_wdata == START_PAT) begin
                r_d.cpu[START_BIT] = 1'b1;
                r_d.mbox           = '0;
            end else if (bus_wdata == HALT_PAT) begin
                r_d.cpu[HALT_BIT]  = 1'b1;
            end else begin
                r_d.cpu            = bus_wdata;
            end
        end
        if (bus_wr && hit && sel == SEL_MBOX) begin
            r_d.mbox = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // read-back path, valid in the strobe cycle
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && hit) begin
            unique case (sel)
                SEL_ICTL: bus_rdata = r_q.ctl[0];
                SEL_IDAT: bus_rdata = mem_rd[0];
                SEL_DCTL: bus_rdata = r_q.ctl[1] & FIELD_MASK;
                SEL_DDAT: bus_rdata = mem_rd[1];
                SEL_CPU:  bus_rdata = r_q.cpu;
                SEL_MBOX: bus_rdata = r_q.mbox;
                SEL_CFG0: bus_rdata = CFG0_VAL;
                SEL_CFG1: bus_rdata = CFG1_VAL;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R3: incrementing write moves instruction index on by one word
    a_r3_winc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dat_hit[0] && r_q.ctl[0][WINC_BIT])
        |=> (r_q.ctl[0][IDX_W+1:2] == IDX_W'($past(r_q.ctl[0][IDX_W+1:2]) + 1'b1)));

    // R5: non-incrementing data write leaves data control untouched
    a_r5_noinc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dat_hit[1] && !r_q.ctl[1][WINC_BIT])
        |=> $stable(r_q.ctl[1]));

    // R6: window accesses never alter bits outside [15:2]
    a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && (dat_hit != '0))
        |=> ($stable(r_q.ctl[0] & ~FIELD_MASK) && $stable(r_q.ctl[1] & ~FIELD_MASK)));

    // R7: data control view hides everything except bits [15:2]
    a_r7_dctl_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit && sel == SEL_DCTL) |-> ((bus_rdata & ~FIELD_MASK) == '0));

    // R9: start command clears mailbox and raises start bit
    a_r9_start_clears_mbox: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit && sel == SEL_CPU && bus_wdata == START_PAT)
        |=> (r_q.mbox == '0 && r_q.cpu[START_BIT]));

    // R12: configuration word 1 is constant
    a_r12_cfg_const: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit && sel == SEL_CFG1) |-> (bus_rdata == CFG1_VAL));

    // R13: unmapped reads return zero
    a_r13_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_lmem_access_port.sv
`timescale 1ns/1ps
module sim_lmem_access_port;

    localparam logic [7:0] A_ICTL = 8'h00, A_IDAT = 8'h04, A_DCTL = 8'h08, A_DDAT = 8'h0C;
    localparam logic [7:0] A_CPU  = 8'h10, A_MBOX = 8'h14, A_CFG0 = 8'h18, A_CFG1 = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lmem_access_port #(.MEM_BYTES(1024), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%08h expected=%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(req, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk(A_ICTL, 32'h0, "R1 ictl");
        rd_chk(A_DCTL, 32'h0, "R1 dctl");
        rd_chk(A_CPU,  32'h0, "R1 cpu");
        rd_chk(A_MBOX, 32'h0, "R1 mbox");
        rd_chk(A_IDAT, 32'h0, "R1 imem word");
        rd_chk(A_DDAT, 32'h0, "R1 dmem word");
        rd_chk(A_CFG0, 32'h0000_0804, "R12 cfg0");
        rd_chk(A_CFG1, 32'h0000_1100, "R12 cfg1");
    endtask

    task automatic t_stream;
        wr(A_ICTL, 32'h0150_0010);
        wr(A_IDAT, 32'hA1A1_0001);
        wr(A_IDAT, 32'hA2A2_0002);
        wr(A_IDAT, 32'hA3A3_0003);
        rd_chk(A_ICTL, 32'h0150_001C, "R3 R6 R7 ictl after 3 writes");
        wr(A_ICTL, 32'h0200_0010);
        rd_chk(A_IDAT, 32'hA1A1_0001, "R4 word 4");
        rd_chk(A_IDAT, 32'hA2A2_0002, "R4 word 5");
        rd_chk(A_IDAT, 32'hA3A3_0003, "R4 word 6");
        rd_chk(A_ICTL, 32'h0200_001C, "R4 R6 ictl after 3 reads");
    endtask

    task automatic t_no_increment;
        wr(A_ICTL, 32'h0000_0014);
        rd_chk(A_IDAT, 32'hA2A2_0002, "R5 read no inc first");
        rd_chk(A_IDAT, 32'hA2A2_0002, "R5 read no inc second");
        rd_chk(A_ICTL, 32'h0000_0014, "R5 ictl held");
        wr(A_DCTL, 32'h00F0_0020);
        wr(A_DDAT, 32'h1234_5678);
        wr(A_DDAT, 32'hCAFE_0001);
        rd_chk(A_DCTL, 32'h0000_0020, "R5 R7 dctl held and masked");
        rd_chk(A_DDAT, 32'hCAFE_0001, "R5 second write overwrote");
    endtask

    task automatic t_dctl_view;
        wr(A_DCTL, 32'h0200_0020);
        rd_chk(A_DDAT, 32'hCAFE_0001, "R4 data read inc");
        rd_chk(A_DCTL, 32'h0000_0024, "R7 dctl masked after advance");
    endtask

    task automatic t_independence;
        wr(A_DCTL, 32'h0000_0010);
        rd_chk(A_DDAT, 32'h0, "R8 dmem word 4 untouched");
        wr(A_ICTL, 32'h0000_0020);
        rd_chk(A_IDAT, 32'h0, "R8 imem word 8 untouched");
    endtask

    task automatic t_addr_forms;
        wr(A_DCTL, 32'h0000_0023);
        rd_chk(A_DDAT, 32'hCAFE_0001, "R2 low bits ignored");
        wr(A_DCTL, 32'h0000_0420);
        rd_chk(A_DDAT, 32'hCAFE_0001, "R2 high bits wrap");
    endtask

    task automatic t_wrap;
        wr(A_ICTL, 32'h0100_03FF);
        wr(A_IDAT, 32'h5A5A_5A5A);
        rd_chk(A_ICTL, 32'h0100_0003, "R14 R6 wrap to 0");
        wr(A_ICTL, 32'h0000_03FC);
        rd_chk(A_IDAT, 32'h5A5A_5A5A, "R14 last word stored");
        wr(A_ICTL, 32'h0000_0000);
        rd_chk(A_IDAT, 32'h0, "R14 word 0 untouched");
    endtask

    task automatic t_cpu_mbox;
        wr(A_CPU, 32'h0000_0040);
        rd_chk(A_CPU, 32'h0000_0040, "R11 plain cpu write");
        wr(A_MBOX, 32'hDEAD_BEEF);
        rd_chk(A_MBOX, 32'hDEAD_BEEF, "R11 mailbox");
        wr(A_CPU, 32'h0000_0010);
        rd_chk(A_CPU, 32'h0000_0050, "R10 halt ORed");
        wr(A_CPU, 32'h0000_0002);
        rd_chk(A_CPU, 32'h0000_0052, "R9 start ORed");
        rd_chk(A_MBOX, 32'h0, "R9 mailbox cleared");
        wr(A_CPU, 32'h0000_0003);
        rd_chk(A_CPU, 32'h0000_0003, "R11 non-pattern stored");
    endtask

    task automatic t_cfg_unmapped;
        wr(A_CFG0, 32'hFFFF_FFFF);
        wr(A_CFG1, 32'h0);
        rd_chk(A_CFG0, 32'h0000_0804, "R12 cfg0 write ignored");
        rd_chk(A_CFG1, 32'h0000_1100, "R12 cfg1 write ignored");
        wr(8'h20, 32'h7777_7777);
        wr(8'h12, 32'h7777_7777);
        rd_chk(8'h20, 32'h0, "R13 unmapped read");
        rd_chk(8'h11, 32'h0, "R13 misaligned read");
        rd_chk(A_CPU, 32'h0000_0003, "R13 unmapped write ignored");
        rd_chk(A_MBOX, 32'h0, "R13 mailbox untouched");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stream();
        t_no_increment();
        t_dctl_view();
        t_independence();
        t_addr_forms();
        t_wrap();
        t_cpu_mbox();
        t_cfg_unmapped();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule